// File: doc/BRIEF.md
# Tagged Debug Word FIFO Peripheral

This peripheral carries 32-bit words in both directions between a processor and an external debug probe. On the processor side it is a small register file with a plain read/write strobe interface. Sixteen transmit addresses all feed one shared transmit FIFO. The address that is written decides the 4-bit channel tag stored with the word. The probe drains that FIFO through a valid/ready port that shows the word and its tag.

In the other direction, the probe pushes tagged words into a receive FIFO. Software reads the status register to learn the channel of the word at the head, then reads the receive data register to take it.

A single interrupt output combines two conditions. Each condition is chosen at run time by a 2-bit threshold code for its FIFO. The interrupt is evaluated from the current occupancy, so it follows pushes and pops in the same cycle as the count changes.

Top module: `dbgch_regs`

## Requirements
- R1: After reset both FIFOs are empty. The status register then reads TX empty (bit 1) and RX empty (bit 3) set, with both counts zero. Both threshold fields read zero and the interrupt output is low.
- R2: The configuration register (offset 0x08) has these fields:
  - the RX depth, read-only, in bits 7:0;
  - the TX depth, read-only, in bits 15:8;
  - the RX threshold code, writable, in bits 17:16;
  - the TX threshold code, writable, in bits 19:18.
  All other bits read zero.
- R3: A write to offset 0x20 + 8·n (n = 0..15) pushes the data word, tagged with n, into the TX FIFO. The probe port presents the words in write order, each with its tag, and a word leaves the FIFO when valid and ready are both high at a clock edge.
- R4: The status register (offset 0x10) reports TX occupancy in bits 31:24 and TX full in bit 0. A write to a transmit address while TX is full is dropped: the count stays at the depth, and the queued words drain unchanged.
- R5: A probe word enters the RX FIFO when valid and ready are both high. The status register reports the following:
  - the head word's channel in bits 7:4;
  - RX empty in bit 3;
  - RX full in bit 2;
  - RX occupancy in bits 23:16.
  A read of offset 0x18 returns the head word and removes it.
- R6: A read of offset 0x18 while RX is empty returns zero and removes nothing.
- R7: The RX ready output to the probe is low exactly when RX is full, so a word offered then is not taken. TX valid to the probe is high exactly when TX is not empty.
- R8: The TX condition depends on the TX threshold code:
  - 0: never true;
  - 1: true when TX is empty;
  - 2: true when TX is not full;
  - 3: true when TX occupancy is at most one quarter of the depth.
- R9: The RX condition depends on the RX threshold code:
  - 0: never true;
  - 1: true when RX is full;
  - 2: true when RX is not empty;
  - 3: true when RX occupancy is at least three quarters of the depth.
  The interrupt output is the OR of the TX and RX conditions.
- R10: The access-control register at offset 0x00 reads as zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_rd |
| probe_tx_valid | output | 1 | TX FIFO head is available to the probe |
| probe_tx_ready | input | 1 | Probe takes the TX head word |
| probe_tx_data | output | 32 | TX head data |
| probe_tx_chan | output | 4 | TX head channel tag |
| probe_rx_valid | input | 1 | Probe offers a word |
| probe_rx_ready | output | 1 | RX FIFO can accept a word |
| probe_rx_data | input | 32 | Offered data |
| probe_rx_chan | input | 4 | Offered channel tag |
| irq | output | 1 | Interrupt request |

## Verification
A wrong pointer or count inside either FIFO shows up as a status count that disagrees with the number of accepted words, on the very next status read. It also shows up as out-of-order or mis-tagged words at the probe or on receive reads. A wrong threshold decode shows on the interrupt pin at the exact occupancy where the chosen code should change state, so the sweeps step the occupancy one word at a time through every code. Dropped-write and empty-read faults surface as an extra word, or a missing one, when the FIFO is drained.

// File: rtl/dbgch_pkg.sv
package dbgch_pkg;

    localparam logic [7:0] OFS_ACCESS = 8'h00;
    localparam logic [7:0] OFS_CONFIG = 8'h08;
    localparam logic [7:0] OFS_STATUS = 8'h10;
    localparam logic [7:0] OFS_RXDATA = 8'h18;
    localparam int         TX_SLOT_FIRST = 4;   // 0x20 >> 3
    localparam int         TX_SLOT_LAST  = 19;  // 0x98 >> 3

    typedef enum logic [1:0] {
        TXT_OFF       = 2'd0,
        TXT_EMPTY     = 2'd1,
        TXT_NOTFULL   = 2'd2,
        TXT_NEAREMPTY = 2'd3
    } tx_thr_e;

    typedef enum logic [1:0] {
        RXT_OFF      = 2'd0,
        RXT_FULL     = 2'd1,
        RXT_NOTEMPTY = 2'd2,
        RXT_NEARFULL = 2'd3
    } rx_thr_e;

    typedef struct packed {
        logic [3:0]  chan;
        logic [31:0] data;
    } tagged_word_t;

endpackage

// File: rtl/dbgch_fifo.sv
module dbgch_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 36,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CMAX = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == CMAX);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R4
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CMAX);
    // R4
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count == CMAX));
    // R6
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (count == '0));
endmodule

// File: rtl/dbgch_irq.sv
module dbgch_irq
    import dbgch_pkg::*;
#(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8,
    localparam int TCW = $clog2(TX_DEPTH + 1),
    localparam int RCW = $clog2(RX_DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  tx_thr_e        tx_code,
    input  rx_thr_e        rx_code,
    input  logic [TCW-1:0] tx_count,
    input  logic [RCW-1:0] rx_count,
    output logic           irq
);
    logic [31:0] tx_n, rx_n;
    logic        tx_hit, rx_hit;

    assign tx_n = 32'(tx_count);
    assign rx_n = 32'(rx_count);

    always_comb begin
        unique case (tx_code)
            TXT_OFF:       tx_hit = 1'b0;
            TXT_EMPTY:     tx_hit = (tx_n == 0);
            TXT_NOTFULL:   tx_hit = (tx_n < 32'(TX_DEPTH));
            TXT_NEAREMPTY: tx_hit = ((tx_n * 4) <= 32'(TX_DEPTH));
            default:       tx_hit = 1'b0;
        endcase
    end

    always_comb begin
        unique case (rx_code)
            RXT_OFF:      rx_hit = 1'b0;
            RXT_FULL:     rx_hit = (rx_n == 32'(RX_DEPTH));
            RXT_NOTEMPTY: rx_hit = (rx_n != 0);
            RXT_NEARFULL: rx_hit = ((rx_n * 4) >= 32'(RX_DEPTH * 3));
            default:      rx_hit = 1'b0;
        endcase
    end

    assign irq = tx_hit | rx_hit;

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_code == TXT_OFF && rx_code == RXT_OFF) |-> !irq);
    // R8
    tx_empty_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_code == TXT_EMPTY && tx_count == '0) |-> irq);
endmodule

// File: rtl/dbgch_regs.sv
module dbgch_regs
    import dbgch_pkg::*;
#(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8,
    localparam int TCW = $clog2(TX_DEPTH + 1),
    localparam int RCW = $clog2(RX_DEPTH + 1),
    localparam int WW  = $bits(tagged_word_t)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        probe_tx_valid,
    input  logic        probe_tx_ready,
    output logic [31:0] probe_tx_data,
    output logic [3:0]  probe_tx_chan,
    input  logic        probe_rx_valid,
    output logic        probe_rx_ready,
    input  logic [31:0] probe_rx_data,
    input  logic [3:0]  probe_rx_chan,
    output logic        irq
);
    tx_thr_e        tx_code;
    rx_thr_e        rx_code;
    tagged_word_t   tx_in, tx_head, rx_in, rx_head;
    logic [TCW-1:0] tx_count;
    logic [RCW-1:0] rx_count;
    logic           tx_full, tx_empty, rx_full, rx_empty;
    logic           is_tx_slot, tx_push, rx_push, rx_pop;
    logic [4:0]     slot;
    logic [3:0]     wr_chan;
    logic           unused_bits;

    assign unused_bits = ^{bus_wdata[31:20], bus_wdata[15:0]};

    assign slot       = bus_addr[7:3];
    assign is_tx_slot = (bus_addr[2:0] == 3'b000) &&
                        (int'(slot) >= TX_SLOT_FIRST) && (int'(slot) <= TX_SLOT_LAST);
    assign wr_chan    = 4'(slot - 5'(TX_SLOT_FIRST));
    assign tx_push    = bus_wr && is_tx_slot;
    assign tx_in      = '{chan: wr_chan, data: bus_wdata};
    assign rx_in      = '{chan: probe_rx_chan, data: probe_rx_data};
    assign rx_push    = probe_rx_valid && !rx_full;
    assign rx_pop     = bus_rd && (bus_addr == OFS_RXDATA) && !rx_empty;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_code <= TXT_OFF;
            rx_code <= RXT_OFF;
        end else if (bus_wr && bus_addr == OFS_CONFIG) begin
            tx_code <= tx_thr_e'(bus_wdata[19:18]);
            rx_code <= rx_thr_e'(bus_wdata[17:16]);
        end
    end

    dbgch_fifo #(.DEPTH(TX_DEPTH), .WIDTH(WW)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .push_data(tx_in),
        .pop(probe_tx_valid && probe_tx_ready), .head(tx_head),
        .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    dbgch_fifo #(.DEPTH(RX_DEPTH), .WIDTH(WW)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_data(rx_in),
        .pop(rx_pop), .head(rx_head),
        .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    dbgch_irq #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .tx_code(tx_code), .rx_code(rx_code),
        .tx_count(tx_count), .rx_count(rx_count), .irq(irq)
    );

    assign probe_tx_valid = !tx_empty;
    assign probe_tx_data  = tx_head.data;
    assign probe_tx_chan  = tx_head.chan;
    assign probe_rx_ready = !rx_full;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                OFS_CONFIG: bus_rdata = {12'h000, tx_code, rx_code,
                                         8'(TX_DEPTH), 8'(RX_DEPTH)};
                OFS_STATUS: bus_rdata = {8'(tx_count), 8'(rx_count), 8'h00,
                                         rx_empty ? 4'h0 : rx_head.chan,
                                         rx_empty, rx_full, tx_empty, tx_full};
                OFS_RXDATA: bus_rdata = rx_empty ? 32'h0 : rx_head.data;
                default:    bus_rdata = '0;
            endcase
        end
    end

    // R3
    tx_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && tx_empty) |=> (probe_tx_valid && probe_tx_chan == $past(wr_chan)));
    // R6
    rx_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_RXDATA && rx_empty && !probe_rx_valid)
        |=> (rx_count == '0));
    // R7
    rx_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_rx_valid && !probe_rx_ready && !rx_pop) |=> $stable(rx_count));
endmodule

// File: tb/dbgch_regs_tb.sv
module dbgch_regs_tb;
    localparam int D = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        probe_tx_valid, probe_tx_ready = 1'b0;
    logic [31:0] probe_tx_data;
    logic [3:0]  probe_tx_chan;
    logic        probe_rx_valid = 1'b0, probe_rx_ready;
    logic [31:0] probe_rx_data = '0;
    logic [3:0]  probe_rx_chan = '0;
    logic        irq;

    int tests = 0, fails = 0;

    always #4 clk = ~clk;

    dbgch_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .probe_tx_valid(probe_tx_valid), .probe_tx_ready(probe_tx_ready),
        .probe_tx_data(probe_tx_data), .probe_tx_chan(probe_tx_chan),
        .probe_rx_valid(probe_rx_valid), .probe_rx_ready(probe_rx_ready),
        .probe_rx_data(probe_rx_data), .probe_rx_chan(probe_rx_chan), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic probe_push(input logic [3:0] c, input logic [31:0] d);
        @(negedge clk);
        probe_rx_valid = 1'b1; probe_rx_chan = c; probe_rx_data = d;
        @(negedge clk);
        probe_rx_valid = 1'b0;
    endtask

    task automatic probe_take(output logic [3:0] c, output logic [31:0] d);
        @(negedge clk);
        probe_tx_ready = 1'b1;
        #1 c = probe_tx_chan; d = probe_tx_data;
        @(negedge clk);
        probe_tx_ready = 1'b0;
    endtask

    function automatic logic [31:0] status_exp(int tc, int rc, logic [3:0] hc);
        return {8'(tc), 8'(rc), 8'h00, (rc == 0) ? 4'h0 : hc,
                rc == 0, rc == D, tc == 0, tc == D};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [3:0]  c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h10, v); check("R1 status", v, 32'h0000_000A);
        rd(8'h08, v); check("R1/R2 config", v, {12'h0, 4'h0, 8'(D), 8'(D)});
        check("R1 irq", 32'(irq), 0);

        // R10 access register
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v); check("R10 access reads 0", v, 0);
        rd(8'h08, v); check("R10 config untouched", v, {12'h0, 4'h0, 8'(D), 8'(D)});

        // R2 all threshold combinations, depth fields read-only
        for (int k = 0; k < 16; k++) begin
            wr(8'h08, 32'hFFF0_FFFF & ~32'h000F_0000 | (32'(k) << 16));
            rd(8'h08, v); check("R2 config fields", v, {12'h0, 4'(k), 8'(D), 8'(D)});
        end

        // R8 TX threshold sweep, R3 tag/order, R4 full drop
        for (int code = 0; code < 4; code++) begin
            wr(8'h08, 32'(code) << 18);
            for (int k = 0; k <= D; k++) begin
                logic exp_i;
                case (code)
                    1: exp_i = (k == 0);
                    2: exp_i = (k < D);
                    3: exp_i = (k * 4 <= D);
                    default: exp_i = 1'b0;
                endcase
                #1 check($sformatf("R8 tx code %0d occ %0d irq", code, k), 32'(irq), 32'(exp_i));
                rd(8'h10, v); check("R4 tx status", v, status_exp(k, 0, 4'h0));
                check("R7 tx valid", 32'(probe_tx_valid), 32'(k != 0));
                if (k < D) wr(8'h20 + 8'((((k * 5) + code) % 16) * 8), 32'hA000_0000 + 32'(code * 16 + k));
            end
            wr(8'h98, 32'hDEAD_BEEF);   // dropped while full
            rd(8'h10, v); check("R4 full write dropped", v, status_exp(D, 0, 4'h0));
            for (int k = 0; k < D; k++) begin
                probe_take(c, v);
                check("R3 tx data order", v, 32'hA000_0000 + 32'(code * 16 + k));
                check("R3 tx chan tag", 32'(c), 32'(((k * 5) + code) % 16));
            end
            rd(8'h10, v); check("R4 tx drained", v, status_exp(0, 0, 4'h0));
        end

        // R9 RX threshold sweep, R5 status/pop, R7 ready
        for (int code = 0; code < 4; code++) begin
            wr(8'h08, 32'(code) << 16);
            for (int k = 0; k <= D; k++) begin
                logic exp_i;
                case (code)
                    1: exp_i = (k == D);
                    2: exp_i = (k != 0);
                    3: exp_i = (k * 4 >= D * 3);
                    default: exp_i = 1'b0;
                endcase
                #1 check($sformatf("R9 rx code %0d occ %0d irq", code, k), 32'(irq), 32'(exp_i));
                check("R7 rx ready", 32'(probe_rx_ready), 32'(k != D));
                rd(8'h10, v); check("R5 rx status", v, status_exp(0, k, 4'(code + 3)));
                probe_push(4'((code + 3 + k) % 16), 32'hB000_0000 + 32'(code * 16 + k));
            end
            rd(8'h10, v); check("R7 refused when full", v, status_exp(0, D, 4'(code + 3)));
            for (int k = 0; k < D; k++) begin
                rd(8'h10, v); check("R5 head chan", 32'(v[7:4]), 32'((code + 3 + k) % 16));
                rd(8'h18, v); check("R5 rx data pop", v, 32'hB000_0000 + 32'(code * 16 + k));
            end
            rd(8'h18, v); check("R6 empty read zero", v, 0);
            rd(8'h10, v); check("R6 no pop when empty", v, status_exp(0, 0, 4'h0));
        end

        // R9 OR of both conditions
        wr(8'h08, (32'd1 << 18) | (32'd1 << 16));
        #1 check("R9 irq OR tx empty", 32'(irq), 1);
        wr(8'h20, 32'h1);
        #1 check("R9 irq both false", 32'(irq), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule